// File: doc/BRIEF.md
# Dual DAC Buffered Update Controller

This block sits between a host write port and two 12-bit DAC code registers. Each host write is a 16-bit word. The block checks the word's reserved bits, decodes which channel the word targets, and keeps the 12-bit code for that channel. A 2-bit update mode sets when the code reaches the channel's output register.

In direct mode a code goes to its output register on the next clock edge. In the three buffered modes, the code waits in a per-channel buffer. It moves to the output only when the chosen hardware event occurs: a timer overflow pulse, a rising edge on an asynchronous external gate, or a pacer tick. When that event occurs, every channel that holds a waiting code updates in the same clock cycle. This lets software stage both channels and have them change together.

A status output shows whether any buffer still holds a code that has not reached its output. A one-cycle error pulse reports words whose reserved bits are not zero.

Top module: `dac_update_ctrl`

## Requirements
- R1: A word is valid when bits 15:13 are all zero. In a valid word, bits 11:0 are the DAC code and bit 12 picks the channel: 0 targets `dac0_out`, 1 targets `dac1_out`.
- R2: A word with any of bits 15:13 set changes no output, buffer or pending state. In that case `word_err` is high for exactly the one cycle after the write.
- R3: In mode 0 (`upd_mode`=00), a valid write appears on its channel's output after the next rising clock edge. It also clears that channel's pending state.
- R4: In modes 1 (01, timer), 2 (10, gate) and 3 (11, pacer), a valid write leaves the outputs unchanged. The outputs stay unchanged until the event of the current mode occurs. Events that belong to other modes have no effect.
- R5: On the selected event, every channel with a pending code copies it to its output on that same clock edge, and the pending state clears. A channel with no pending code keeps its output.
- R6: `buf_pending` is high from the edge after a buffered write until the event that moves that code. It stays high while any channel still has a pending code.
- R7: `ext_gate` passes through a two-flop synchroniser, and only its rising edge is an event. Outputs update on the third rising clock edge after the gate goes high. Holding the gate high, or taking it low, has no effect.
- R8: A valid buffered write in the same cycle as an event is not moved by that event. It stays pending for the next event. Other channels' pending codes still move.
- R9: With `rst_n` low (asynchronous, active low), both outputs are 0 and `buf_pending` and `word_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 16 | Host data word |
| upd_mode | input | 2 | Update mode: 0 direct, 1 timer, 2 gate, 3 pacer |
| tmr_ovf | input | 1 | Timer overflow pulse, synchronous |
| ext_gate | input | 1 | External gate, asynchronous level |
| pacer_tick | input | 1 | Pacer tick pulse, synchronous |
| dac0_out | output | 12 | Channel 0 output register |
| dac1_out | output | 12 | Channel 1 output register |
| buf_pending | output | 1 | Some channel holds a code not yet moved |
| word_err | output | 1 | One-cycle pulse after a word with reserved bits set |

## Verification
Some properties are checked on every cycle:
- Outputs hold steady when there is neither an event nor a direct write.
- A reserved-bit word touches no output and raises the error pulse.
- An event with no write in the same cycle leaves nothing pending.
- The edge detector never fires on two cycles in a row.

Other behaviour only the bench scenarios can show. These are the exact gate latency, the deferral of a write that collides with an event, the rule that an event from another mode is ignored, the moment both channels change together, and the exact output values.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int DATA_W = 16;
  localparam int CODE_W = 12;
  localparam int NCH    = 2;
  localparam int SEL_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int RSV_LO = CODE_W + SEL_W;

  typedef enum logic [1:0] {
    UPD_DIRECT = 2'd0,
    UPD_TIMER  = 2'd1,
    UPD_GATE   = 2'd2,
    UPD_PACER  = 2'd3
  } upd_mode_e;

  // reserved field must be all zero
  function automatic logic word_ok(input logic [DATA_W-1:0] w);
    return w[DATA_W-1:RSV_LO] == '0;
  endfunction

  function automatic logic [SEL_W-1:0] word_ch(input logic [DATA_W-1:0] w);
    return w[RSV_LO-1:CODE_W];
  endfunction

  function automatic logic [CODE_W-1:0] word_code(input logic [DATA_W-1:0] w);
    return w[CODE_W-1:0];
  endfunction
endpackage

// File: rtl/dacu_gate_sync.sv
module dacu_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_rise
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], gate_in};
  end

  assign gate_rise = sh[STAGES-1] & ~sh[STAGES];

  // R7: an edge is a single-cycle pulse
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);
endmodule

// File: rtl/dacu_event_sel.sv
module dacu_event_sel
  import dacu_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       tmr_ovf,
  input  logic       gate_rise,
  input  logic       pacer_tick,
  output logic       upd_evt,
  output logic       direct
);
  always_comb begin
    upd_evt = 1'b0;
    direct  = 1'b0;
    unique case (upd_mode_e'(mode))
      UPD_DIRECT: direct  = 1'b1;
      UPD_TIMER:  upd_evt = tmr_ovf;
      UPD_GATE:   upd_evt = gate_rise;
      UPD_PACER:  upd_evt = pacer_tick;
      default:    upd_evt = 1'b0;
    endcase
  end

  // R4: direct mode and a hardware event never coexist
  always_comb begin
    a_r4_no_evt_direct: assert (!(direct && upd_evt));
  end
endmodule

// File: rtl/dacu_chan_buf.sv
module dacu_chan_buf #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              direct,
  input  logic              upd_evt,
  output logic [CODE_W-1:0] out_code,
  output logic              pend
);
  logic [CODE_W-1:0] buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      out_code <= '0;
      pend     <= 1'b0;
    end else if (wr_hit && direct) begin
      buf_q    <= wr_code;
      out_code <= wr_code;
      pend     <= 1'b0;
    end else begin
      if (upd_evt && pend) out_code <= buf_q;   // old buffer moves
      if (wr_hit) begin                          // new code waits (R8)
        buf_q <= wr_code;
        pend  <= 1'b1;
      end else if (upd_evt) begin
        pend  <= 1'b0;
      end
    end
  end

  // R4: output only moves on an event or a direct write
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt && !(wr_hit && direct)) |=> $stable(out_code));
  // R6: a buffered write leaves the channel pending
  a_r6_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !direct) |=> pend);
  // R5: an event without a colliding write empties the channel
  a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_hit) |=> !pend);
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dacu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        upd_mode,
  input  logic              tmr_ovf,
  input  logic              ext_gate,
  input  logic              pacer_tick,
  output logic [CODE_W-1:0] dac0_out,
  output logic [CODE_W-1:0] dac1_out,
  output logic              buf_pending,
  output logic              word_err
);
  logic              gate_rise;
  logic              upd_evt;
  logic              direct;
  logic              w_ok;
  logic [SEL_W-1:0]  w_ch;
  logic [CODE_W-1:0] w_code;
  logic [NCH-1:0]    pend;
  logic [CODE_W-1:0] outs [NCH];

  assign w_ok   = word_ok(wr_data);
  assign w_ch   = word_ch(wr_data);
  assign w_code = word_code(wr_data);

  dacu_gate_sync #(.STAGES(2)) u_gate (
    .clk(clk), .rst_n(rst_n), .gate_in(ext_gate), .gate_rise(gate_rise)
  );

  dacu_event_sel u_evt (
    .mode(upd_mode), .tmr_ovf(tmr_ovf), .gate_rise(gate_rise),
    .pacer_tick(pacer_tick), .upd_evt(upd_evt), .direct(direct)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en && w_ok && (w_ch == SEL_W'(i));
    dacu_chan_buf #(.CODE_W(CODE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_code(w_code),
      .direct(direct), .upd_evt(upd_evt), .out_code(outs[i]), .pend(pend[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_err <= 1'b0;
    else        word_err <= wr_en && !w_ok;
  end

  assign dac0_out    = outs[0];
  assign dac1_out    = outs[1];
  assign buf_pending = |pend;

  // R2: rejected word leaves the outputs alone and flags an error
  a_r2_bad_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_ok && !upd_evt) |=> ($stable(dac0_out) && $stable(dac1_out)));
  a_r2_bad_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_ok) |=> word_err);
  // R5: an event with no write leaves nothing pending
  a_r5_all_moved: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !wr_en) |=> !buf_pending);
endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  upd_mode = '0;
  logic        tmr_ovf = 1'b0;
  logic        ext_gate = 1'b0;
  logic        pacer_tick = 1'b0;
  logic [11:0] dac0_out, dac1_out;
  logic        buf_pending, word_err;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dac_update_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .upd_mode(upd_mode), .tmr_ovf(tmr_ovf), .ext_gate(ext_gate),
    .pacer_tick(pacer_tick), .dac0_out(dac0_out), .dac1_out(dac1_out),
    .buf_pending(buf_pending), .word_err(word_err)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] data;
    logic [1:0]  mode;
    logic        tmr;
    logic        pac;
    logic [11:0] e0;
    logic [11:0] e1;
    logic        ep;
    logic        ee;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0123, 2'd0, 1'b0, 1'b0, 12'h123, 12'h000, 1'b0, 1'b0},
    '{1'b1, 16'h1456, 2'd0, 1'b0, 1'b0, 12'h123, 12'h456, 1'b0, 1'b0},
    '{1'b1, 16'h0AAA, 2'd1, 1'b0, 1'b0, 12'h123, 12'h456, 1'b1, 1'b0},
    '{1'b1, 16'h1BBB, 2'd1, 1'b0, 1'b0, 12'h123, 12'h456, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 2'd1, 1'b0, 1'b1, 12'h123, 12'h456, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 2'd1, 1'b1, 1'b0, 12'hAAA, 12'hBBB, 1'b0, 1'b0},
    '{1'b1, 16'h0111, 2'd3, 1'b1, 1'b0, 12'hAAA, 12'hBBB, 1'b1, 1'b0},
    '{1'b1, 16'h1222, 2'd3, 1'b0, 1'b1, 12'h111, 12'hBBB, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 2'd3, 1'b0, 1'b1, 12'h111, 12'h222, 1'b0, 1'b0},
    '{1'b1, 16'h2FFF, 2'd0, 1'b0, 1'b0, 12'h111, 12'h222, 1'b0, 1'b1},
    '{1'b0, 16'h0000, 2'd0, 1'b0, 1'b0, 12'h111, 12'h222, 1'b0, 1'b0},
    '{1'b1, 16'hE000, 2'd0, 1'b0, 1'b0, 12'h111, 12'h222, 1'b0, 1'b1},
    '{1'b1, 16'h1FFF, 2'd0, 1'b0, 1'b0, 12'h111, 12'hFFF, 1'b0, 1'b0},
    '{1'b1, 16'h0000, 2'd0, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 2'd3, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b0, 1'b0},
    '{1'b1, 16'h0ABC, 2'd1, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b1, 1'b0},
    '{1'b1, 16'h4ABC, 2'd1, 1'b0, 1'b0, 12'h000, 12'hFFF, 1'b1, 1'b1},
    '{1'b1, 16'h1123, 2'd0, 1'b0, 1'b0, 12'h000, 12'h123, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 2'd1, 1'b1, 1'b0, 12'hABC, 12'h123, 1'b0, 1'b0}
  };
  // requirement each vector mainly exercises
  string vtag [NV] = '{"R3", "R1", "R4", "R6", "R4", "R5", "R4", "R8", "R8",
                       "R2", "R2", "R2", "R1", "R3", "R5", "R4", "R2", "R6", "R5"};

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_all(input string req, input int e0, input int e1, input int ep, input int ee);
    chk(req, "dac0_out", int'(dac0_out), e0);
    chk(req, "dac1_out", int'(dac1_out), e1);
    chk(req, "buf_pending", int'(buf_pending), ep);
    chk(req, "word_err", int'(word_err), ee);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk_all("R9", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr_en      = VEC[i].wr;
      wr_data    = VEC[i].data;
      upd_mode   = VEC[i].mode;
      tmr_ovf    = VEC[i].tmr;
      pacer_tick = VEC[i].pac;
      @(negedge clk);
      chk_all(vtag[i], int'(VEC[i].e0), int'(VEC[i].e1), int'(VEC[i].ep), int'(VEC[i].ee));
    end
    wr_en = 1'b0; tmr_ovf = 1'b0; pacer_tick = 1'b0;

    // R7: gate mode, three-edge latency
    upd_mode = 2'd2;
    wr_en = 1'b1; wr_data = 16'h0555;
    @(negedge clk);
    wr_en = 1'b0; ext_gate = 1'b1;
    @(negedge clk);
    chk_all("R7", 'hABC, 'h123, 1, 0);
    @(negedge clk);
    chk_all("R7", 'hABC, 'h123, 1, 0);
    @(negedge clk);
    chk_all("R7", 'h555, 'h123, 0, 0);

    // R7: held high and falling level do nothing
    wr_en = 1'b1; wr_data = 16'h1666;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R7", 'h555, 'h123, 1, 0);
    ext_gate = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R7", 'h555, 'h123, 1, 0);
    ext_gate = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R7", 'h555, 'h666, 0, 0);

    // R9: reset mid-run with a pending code
    wr_en = 1'b1; wr_data = 16'h0777;
    @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk_all("R9", 0, 0, 0, 0);
    @(negedge clk);
    chk_all("R9", 0, 0, 0, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule